// File: doc/BRIEF.md
# Pulse-Interval Forward-Link Encoder

This block sends a reader-to-tag command over a low-frequency carrier by turning the field on and off. All timing is counted in carrier cycles, where one carrier cycle is 8 µs. A strobe input, `cyc_tick`, marks each carrier cycle for the block. The command bits arrive already assembled, as a vector plus a bit count. Bit 0 is never sent as data. In its place the block sends a fixed opening pulse with a long field-off period. Each later bit is then sent in turn: a 1 is an unbroken stretch of field on, and a 0 is a short field-off notch followed by field on.

Once the last bit has been sent, the field stays on for a settling wait. This wait is 400 µs after a read command and 6500 µs after a write command. At the end of the wait the block raises a one-cycle capture strobe, which tells the receive path to start sampling the tag's answer. Before the command is sent, the control logic chooses whether it is a read or a write.

Top module: `fwd_link_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `field_on` is 1 and `busy`, `capture` and `err` are 0.
- R2: When a start is accepted, the field goes off for 55 carrier ticks and then on for 18 ticks. This opening pulse is the same whatever the value of bit 0 of `bits`.
- R3: After the opening pulse, bits 1 up to `nbits`-1 of `bits` are sent in rising index order (LSB first), one symbol per bit.
- R4: A bit equal to 1 is sent as 32 carrier ticks with the field on.
- R5: A bit equal to 0 is sent as 23 carrier ticks with the field off, then 18 ticks with the field on.
- R6: After the last symbol, the field stays on for a wait and then `capture` pulses high for exactly one clock. The wait is 50 ticks (400 µs) when `is_write` was 0 at start, and 813 ticks (6500 µs rounded up to whole ticks) when it was 1.
- R7: `busy` goes high in the clock after a start is accepted. It goes low in the same clock that `capture` goes high.
- R8: A start with `nbits` equal to 0 or greater than 64 is refused. `err` pulses for one clock, `busy` stays 0 and the field stays on.
- R9: A start that arrives while `busy` is high has no effect on the frame in progress.
- R10: Bits of `bits` at index `nbits` and above have no effect on the output.
- R11: Time advances only on clocks where `cyc_tick` is 1, so each interval lasts the stated number of ticks whatever the spacing between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One-clock strobe per carrier cycle (8 µs) |
| start | input | 1 | Request to send a frame |
| bits | input | 64 | Command bits, bit 0 replaced by the opening pulse |
| nbits | input | 7 | Number of bits in the frame, 1 to 64 |
| is_write | input | 1 | 1 selects the write wait, 0 the read wait |
| field_on | output | 1 | Carrier enable, 1 means field on |
| busy | output | 1 | Frame or wait in progress |
| capture | output | 1 | One-clock strobe at the end of the wait |
| err | output | 1 | One-clock strobe for a refused start |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a frame. A design that accepted it would reload the shift register and counters. The stimulus drives a second start, with different bits and a different count, partway through a frame of all-zero bits. The scoreboard then requires the original tick-by-tick field pattern and wait length without a break. A second hard case is the tick spacing: frames are run with a tick on every clock and with ticks spread over two and three clocks, so any interval that counts clocks instead of ticks shows up as a pattern mismatch.

// File: rtl/fwd_link_tx.sv
module fwd_link_tx #(
  parameter int MAX_BITS  = 64,
  parameter int LEAD_OFF  = 55,
  parameter int LEAD_ON   = 18,
  parameter int ONE_ON    = 32,
  parameter int NOTCH_OFF = 23,
  parameter int NOTCH_ON  = 18,
  parameter int RD_WAIT   = 50,
  parameter int WR_WAIT   = 813,
  localparam int NW = $clog2(MAX_BITS + 1),
  localparam int M1 = (LEAD_OFF > LEAD_ON) ? LEAD_OFF : LEAD_ON,
  localparam int M2 = (ONE_ON > NOTCH_OFF) ? ONE_ON : NOTCH_OFF,
  localparam int M3 = (NOTCH_ON > RD_WAIT) ? NOTCH_ON : RD_WAIT,
  localparam int M4 = (M1 > M2) ? M1 : M2,
  localparam int M5 = (M3 > WR_WAIT) ? M3 : WR_WAIT,
  localparam int MAXC = (M4 > M5) ? M4 : M5,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc_tick,
  input  logic                start,
  input  logic [MAX_BITS-1:0] bits,
  input  logic [NW-1:0]       nbits,
  input  logic                is_write,
  output logic                field_on,
  output logic                busy,
  output logic                capture,
  output logic                err
);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_MARK, S_HOLD} st_t;

  st_t                st;
  logic [CW-1:0]      cnt;
  logic [MAX_BITS-1:0] sh;
  logic [NW-1:0]      rem;
  logic               lead;
  logic               wr;

  wire count_ok = (nbits != '0) && (nbits <= NW'(MAX_BITS));
  wire done     = cyc_tick && (cnt == CW'(1));

  assign busy     = (st != S_IDLE);
  assign field_on = (st != S_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rem     <= '0;
      lead    <= 1'b0;
      wr      <= 1'b0;
      capture <= 1'b0;
      err     <= 1'b0;
    end else begin
      capture <= 1'b0;
      err     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (count_ok) begin
              st   <= S_GAP;
              cnt  <= CW'(LEAD_OFF);
              sh   <= bits;
              rem  <= nbits - NW'(1);
              lead <= 1'b1;
              wr   <= is_write;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_GAP: begin
          if (done) begin
            st   <= S_MARK;
            cnt  <= lead ? CW'(LEAD_ON) : CW'(NOTCH_ON);
            lead <= 1'b0;
          end else if (cyc_tick) begin
            cnt <= cnt - CW'(1);
          end
        end
        S_MARK: begin
          if (done) begin
            if (rem == '0) begin
              st  <= S_HOLD;
              cnt <= wr ? CW'(WR_WAIT) : CW'(RD_WAIT);
            end else begin
              sh  <= sh >> 1;
              rem <= rem - NW'(1);
              if (sh[1]) begin
                st  <= S_MARK;
                cnt <= CW'(ONE_ON);
              end else begin
                st  <= S_GAP;
                cnt <= CW'(NOTCH_OFF);
              end
            end
          end else if (cyc_tick) begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          if (done) begin
            st      <= S_IDLE;
            capture <= 1'b1;
          end else if (cyc_tick) begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  a_r1_idle_field_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> field_on);

  a_r2_lead_starts_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !field_on);

  a_r6_capture_single: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

  a_r7_capture_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!busy && $past(busy)));

  a_r8_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && field_on && $past(start) && !$past(busy)));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(st == S_HOLD && done)) |=> (busy && !err));

  a_r11_counter_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));

endmodule

// File: tb/tb_fwd_link_tx.sv
module tb_fwd_link_tx;
  localparam int NW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_tick = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   bits = '0;
  logic [NW-1:0] nbits = '0;
  logic          is_write = 1'b0;
  logic          field_on, busy, capture, err;

  fwd_link_tx dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .start(start),
    .bits(bits), .nbits(nbits), .is_write(is_write),
    .field_on(field_on), .busy(busy), .capture(capture), .err(err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int tick_div = 1;
  int tcnt = 0;
  bit expq[$];
  int mism = 0;
  bit frame_done = 0;
  bit prev_busy = 0;
  bit prev_cap = 0;
  string cur_tag = "";
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tcnt <= tcnt + 1;
    cyc_tick <= ((tcnt % tick_div) == 0);
  end

  // monitor: pops one expected field value per consumed tick
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && cyc_tick) begin
        if (expq.size() == 0) mism++;
        else if (expq.pop_front() != field_on) mism++;
      end
      if (capture) begin
        chk(mism == 0, {cur_tag, " field pattern mismatches"}, mism, 0);
        chk(expq.size() == 0, {cur_tag, " R6 wait length, ticks left"}, expq.size(), 0);
        chk(!busy && prev_busy, "R7 busy falls with capture", {busy, prev_busy}, 2'b01);
        frame_done = 1;
      end
      if (prev_cap) chk(!capture, "R6 capture one clock", capture, 0);
      prev_busy = busy;
      prev_cap = capture;
    end
  end

  task automatic push_n(input bit v, input int n);
    for (int i = 0; i < n; i++) expq.push_back(v);
  endtask

  task automatic send_frame(input logic [63:0] b, input int n, input bit wr,
                            input bit poke, input string tag);
    int w;
    expq.delete();
    mism = 0;
    frame_done = 0;
    cur_tag = tag;
    push_n(0, 55);
    push_n(1, 18);
    for (int k = 1; k < n; k++) begin
      if (b[k]) push_n(1, 32);
      else begin
        push_n(0, 23);
        push_n(1, 18);
      end
    end
    push_n(1, wr ? 813 : 50);
    @(posedge clk);
    start <= 1'b1; bits <= b; nbits <= NW'(n); is_write <= wr;
    @(posedge clk);
    start <= 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin
      repeat (200) @(posedge clk);
      start <= 1'b1; bits <= ~b; nbits <= 7'd3; is_write <= ~wr;
      @(posedge clk);
      start <= 1'b0;
    end
    w = 0;
    while (!frame_done && w < 20000) begin
      @(posedge clk);
      w++;
    end
    chk(frame_done, {tag, " frame completes"}, frame_done, 1);
    @(negedge clk);
    @(negedge clk);
    chk(field_on && !busy, "R1 idle field high after frame", {field_on, busy}, 2'b10);
  endtask

  task automatic reject(input int n);
    @(posedge clk);
    start <= 1'b1; nbits <= NW'(n); bits <= 64'hFFFF;
    @(posedge clk);
    start <= 1'b0;
    @(negedge clk);
    chk(err && !busy && field_on, "R8 refused count err/busy/field",
        {err, busy, field_on}, 3'b101);
    @(negedge clk);
    chk(!err && !busy && field_on, "R8 err one clock, still idle",
        {err, busy, field_on}, 3'b001);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(field_on && !busy && !capture && !err, "R1 reset state",
        {field_on, busy, capture, err}, 4'b1000);
    rst_n <= 1'b1;
    repeat (3) @(posedge clk);

    tick_div = 1;
    send_frame(64'h1, 1, 1'b0, 1'b0, "R2 single-bit read");
    send_frame(64'hA5, 8, 1'b0, 1'b0, "R3 R4 R5 A5 read");
    tick_div = 3;
    send_frame(64'h0123_4567_89AB_CDEF, 64, 1'b1, 1'b0, "R3 R11 64-bit write");
    tick_div = 2;
    send_frame(64'hFFFF_FFFF_FFFF_FFE6, 5, 1'b1, 1'b0, "R10 upper bits write");
    tick_div = 1;
    send_frame(64'h0, 16, 1'b0, 1'b1, "R9 R5 zeros with mid-frame start");
    reject(0);
    reject(65);
    reject(127);
    send_frame(64'hFFFF_FFFF_FFFF_FFFE, 64, 1'b0, 1'b0, "R4 R2 ones read");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule